// File: doc/BRIEF.md
# Registered Parity Bus Transceiver

This block moves two byte lanes, each carrying eight data bits and one parity bit, between an A side and a B side. There is one path from A to B and a separate path from B to A. Each path has its own storage stage, and that stage works in one of three ways: it can pass data straight through, hold a stored word, or capture a new word on a clock tick. Each lane of a path has its own active-low capture enable, so the two lanes of one path can be loaded separately.

A shared mode input chooses between two parity behaviours. In the first, each outgoing lane gets a parity bit recomputed from its data, and the parity received on the way in is checked. In the second, all nine bits of each lane pass through untouched. A sense input chooses between odd and even parity. Each side has an active-low error flag. Each bidirectional pin is split into three ports: an input, an output, and an output enable. The block runs on one core clock. The per-path capture tick is a strobe sampled on that clock.

Top module: `rpb_xcvr`

## Requirements
- R1: After a synchronous active-low reset, all stored data and parity bits are zero. With both paths holding and parity bypassed, both sides output all-zero data and parity, and both error flags read high.
- R2: While a path's latch enable is high, its output data and parity equal the current input in the same cycle, with the same polarity. The stage also reloads on every clock while the latch enable is high.
- R3: When the latch enable is low, the tick is high and a lane's enable is low at a clock edge, that lane stores its input. The stored value appears at the output after the edge.
- R4: When the latch enable is low and either the tick is low or the lane's enable is high, the lane keeps its stored value whatever its input does.
- R5: The two lane enables act on their own lanes only. Lane 0 is bits [7:0] with parity bit 0, and lane 1 is bits [15:8] with parity bit 1.
- R6: When the parity mode input is high (bypass), each output parity bit equals the parity bit that the stage is presenting.
- R7: When the parity mode input is low (generate), each output parity bit is the XOR of that lane's eight data bits, inverted when the sense input is high. Sense high gives an odd count of ones over the nine bits, and sense low gives an even count.
- R8: The error flag of a side is low exactly when the parity mode input is low and at least one lane that the path from that side presents has a parity bit different from the value R7 computes. In bypass mode the flag is high.
- R9: A side's output enable is high exactly when the active-low output enable for the path that drives that side is low.
- R10: The two paths are independent. Controls and data of one path never change what the other path outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_mode_n | input | 1 | Low: generate and check parity; high: bypass |
| odd_sel | input | 1 | High: odd parity; low: even parity |
| ab_le | input | 1 | A-to-B latch enable (transparent when high) |
| ab_tick | input | 1 | A-to-B capture strobe |
| ab_ce_n | input | 2 | A-to-B per-lane active-low capture enable |
| ab_oe_n | input | 1 | Active-low enable for driving the B side |
| ba_le | input | 1 | B-to-A latch enable |
| ba_tick | input | 1 | B-to-A capture strobe |
| ba_ce_n | input | 2 | B-to-A per-lane active-low capture enable |
| ba_oe_n | input | 1 | Active-low enable for driving the A side |
| a_data_in | input | 16 | Data received on the A side |
| a_par_in | input | 2 | Parity received on the A side |
| b_data_in | input | 16 | Data received on the B side |
| b_par_in | input | 2 | Parity received on the B side |
| a_data_out | output | 16 | Data driven on the A side |
| a_par_out | output | 2 | Parity driven on the A side |
| a_oe | output | 1 | A side output enable |
| b_data_out | output | 16 | Data driven on the B side |
| b_par_out | output | 2 | Parity driven on the B side |
| b_oe | output | 1 | B side output enable |
| err_a_n | output | 1 | Active-low parity error on data received from A |
| err_b_n | output | 1 | Active-low parity error on data received from B |

## Verification
The bench targets the edge where the latch enable falls. If the stage did not reload while it was transparent, the output would drop back to an older word at that edge. It loads one lane alone to catch lane enables that are swapped or shared, which would corrupt the neighbouring byte. It sweeps all combinations of mode, sense and enables against an arithmetic model. A wrong odd/even polarity shows as inverted parity outputs, and checking in bypass mode shows as spurious error flags. Random traffic runs on the opposite path during the sweep, so any coupling between the two directions shows as corrupted outputs.

// File: rtl/rpb_pkg.sv
// Shared types for the registered parity transceiver.
// Assumes a single core clock; capture ticks are strobes in that domain.
package rpb_pkg;

    // What a storage lane does in the current cycle
    typedef enum logic [1:0] {
        STG_HOLD    = 2'd0,
        STG_PASS    = 2'd1,
        STG_CAPTURE = 2'd2
    } stg_mode_e;

    // Decode the per-lane storage behaviour from the path controls
    function automatic stg_mode_e stage_mode(input logic le, input logic tick, input logic ce_n);
        if (le)
            return STG_PASS;
        else if (tick && !ce_n)
            return STG_CAPTURE;
        else
            return STG_HOLD;
    endfunction

endpackage

// File: rtl/rpb_stage.sv
// One direction's storage stage: per lane, a data word plus parity bit.
// Transparent while le is high (also reloading each clock), captures on a
// clock edge with tick high and the lane enable low, otherwise holds.
// Assumes synchronous active-low reset clears all storage.
module rpb_stage
    import rpb_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     le,
    input  logic                     tick,
    input  logic [LANES-1:0]         ce_n,
    input  logic [LANES*LANE_W-1:0]  d_in,
    input  logic [LANES-1:0]         p_in,
    output logic [LANES*LANE_W-1:0]  d_out,
    output logic [LANES-1:0]         p_out
);

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            stg_mode_e         mode;
            logic [LANE_W-1:0] d_q;
            logic              p_q;

            // Decide this lane's storage action
            always_comb mode = stage_mode(le, tick, ce_n[g]);

            // Lane storage register with synchronous clear
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    d_q <= '0;
                    p_q <= 1'b0;
                end else if (mode != STG_HOLD) begin
                    d_q <= d_in[g*LANE_W +: LANE_W];
                    p_q <= p_in[g];
                end
            end

            // Present input while transparent, else the stored value
            assign d_out[g*LANE_W +: LANE_W] = le ? d_in[g*LANE_W +: LANE_W] : d_q;
            assign p_out[g]                  = le ? p_in[g] : p_q;
        end
    endgenerate

endmodule

// File: rtl/rpb_parity.sv
// Per-direction parity generate/check on the stage output.
// With gen_en high, each lane's outgoing parity is recomputed and the
// presented parity is compared; with gen_en low, parity passes unchanged.
// Assumes odd_sel high means an odd count of ones over data plus parity.
module rpb_parity #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                     gen_en,
    input  logic                     odd_sel,
    input  logic [LANES*LANE_W-1:0]  d,
    input  logic [LANES-1:0]         p_raw,
    output logic [LANES-1:0]         p_out,
    output logic                     err
);

    logic [LANES-1:0] mism;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic calc;
            // Parity bit required by the selected sense
            assign calc     = (^d[g*LANE_W +: LANE_W]) ^ odd_sel;
            // Replace or forward the lane's parity bit
            assign p_out[g] = gen_en ? calc : p_raw[g];
            // Flag a lane whose presented parity disagrees
            assign mism[g]  = gen_en && (p_raw[g] != calc);
        end
    endgenerate

    // Any lane in error raises the path error
    assign err = |mism;

endmodule

// File: rtl/rpb_xcvr.sv
// Top of the registered parity transceiver: an A-to-B and a B-to-A path,
// each a storage stage followed by a parity generate/check unit.
// Assumes pins are split into input, output and output-enable ports.
module rpb_xcvr #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     par_mode_n,
    input  logic                     odd_sel,
    input  logic                     ab_le,
    input  logic                     ab_tick,
    input  logic [LANES-1:0]         ab_ce_n,
    input  logic                     ab_oe_n,
    input  logic                     ba_le,
    input  logic                     ba_tick,
    input  logic [LANES-1:0]         ba_ce_n,
    input  logic                     ba_oe_n,
    input  logic [LANES*LANE_W-1:0]  a_data_in,
    input  logic [LANES-1:0]         a_par_in,
    input  logic [LANES*LANE_W-1:0]  b_data_in,
    input  logic [LANES-1:0]         b_par_in,
    output logic [LANES*LANE_W-1:0]  a_data_out,
    output logic [LANES-1:0]         a_par_out,
    output logic                     a_oe,
    output logic [LANES*LANE_W-1:0]  b_data_out,
    output logic [LANES-1:0]         b_par_out,
    output logic                     b_oe,
    output logic                     err_a_n,
    output logic                     err_b_n
);

    localparam int DW = LANES * LANE_W;

    logic [DW-1:0]    ab_d, ba_d;
    logic [LANES-1:0] ab_p, ba_p;
    logic             ab_err, ba_err;
    logic             gen_en;

    // Parity functions are active when the mode input is low
    assign gen_en = !par_mode_n;

    rpb_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_ab_stage (
        .clk(clk), .rst_n(rst_n), .le(ab_le), .tick(ab_tick), .ce_n(ab_ce_n),
        .d_in(a_data_in), .p_in(a_par_in), .d_out(ab_d), .p_out(ab_p)
    );

    rpb_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_ba_stage (
        .clk(clk), .rst_n(rst_n), .le(ba_le), .tick(ba_tick), .ce_n(ba_ce_n),
        .d_in(b_data_in), .p_in(b_par_in), .d_out(ba_d), .p_out(ba_p)
    );

    rpb_parity #(.LANES(LANES), .LANE_W(LANE_W)) u_ab_par (
        .gen_en(gen_en), .odd_sel(odd_sel), .d(ab_d), .p_raw(ab_p),
        .p_out(b_par_out), .err(ab_err)
    );

    rpb_parity #(.LANES(LANES), .LANE_W(LANE_W)) u_ba_par (
        .gen_en(gen_en), .odd_sel(odd_sel), .d(ba_d), .p_raw(ba_p),
        .p_out(a_par_out), .err(ba_err)
    );

    // Drive data and enables toward each side; flags are active low
    assign b_data_out = ab_d;
    assign a_data_out = ba_d;
    assign b_oe       = !ab_oe_n;
    assign a_oe       = !ba_oe_n;
    assign err_a_n    = !ab_err;
    assign err_b_n    = !ba_err;

endmodule

// File: rtl/rpb_xcvr_chk.sv
// Assertion checker for rpb_xcvr, attached by bind. Checks lane 0 of the
// A-to-B path for storage behaviour and both sides for parity behaviour.
module rpb_xcvr_chk #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     par_mode_n,
    input logic                     odd_sel,
    input logic                     ab_le,
    input logic                     ab_tick,
    input logic [LANES-1:0]         ab_ce_n,
    input logic                     ab_oe_n,
    input logic [LANES*LANE_W-1:0]  a_data_in,
    input logic [LANES*LANE_W-1:0]  b_data_out,
    input logic [LANES-1:0]         b_par_out,
    input logic                     b_oe,
    input logic                     err_a_n,
    input logic                     err_b_n
);

    // R2
    transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ab_le |-> (b_data_out == a_data_in));

    // R3
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && ab_tick && !ab_ce_n[0]) |=>
        (ab_le || b_data_out[LANE_W-1:0] == $past(a_data_in[LANE_W-1:0])));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && (ab_ce_n[0] || !ab_tick)) |=>
        (ab_le || $stable(b_data_out[LANE_W-1:0])));

    // R7
    gen_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !par_mode_n |-> (b_par_out[0] == ((^b_data_out[LANE_W-1:0]) ^ odd_sel)));

    // R8
    bypass_noerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_mode_n |-> (err_a_n && err_b_n));

    // R9
    drive_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_oe != ab_oe_n);

endmodule

bind rpb_xcvr rpb_xcvr_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_rpb_chk (
    .clk(clk), .rst_n(rst_n), .par_mode_n(par_mode_n), .odd_sel(odd_sel),
    .ab_le(ab_le), .ab_tick(ab_tick), .ab_ce_n(ab_ce_n), .ab_oe_n(ab_oe_n),
    .a_data_in(a_data_in), .b_data_out(b_data_out), .b_par_out(b_par_out),
    .b_oe(b_oe), .err_a_n(err_a_n), .err_b_n(err_b_n)
);

// File: tb/test_rpb_xcvr.sv
`timescale 1ns/1ps
// Self-checking bench: directed storage checks, then a sweep of all
// control combinations against an arithmetic reference.
module test_rpb_xcvr;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        par_mode_n, odd_sel;
    logic        ab_le, ab_tick, ab_oe_n, ba_le, ba_tick, ba_oe_n;
    logic [1:0]  ab_ce_n, ba_ce_n;
    logic [15:0] a_data_in, b_data_in, a_data_out, b_data_out;
    logic [1:0]  a_par_in, b_par_in, a_par_out, b_par_out;
    logic        a_oe, b_oe, err_a_n, err_b_n;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // Reference storage per path
    logic [15:0] m_ab_d, m_ba_d;
    logic [1:0]  m_ab_p, m_ba_p;

    always #2 clk = ~clk;

    rpb_xcvr i_rpb_xcvr (
        .clk(clk), .rst_n(rst_n), .par_mode_n(par_mode_n), .odd_sel(odd_sel),
        .ab_le(ab_le), .ab_tick(ab_tick), .ab_ce_n(ab_ce_n), .ab_oe_n(ab_oe_n),
        .ba_le(ba_le), .ba_tick(ba_tick), .ba_ce_n(ba_ce_n), .ba_oe_n(ba_oe_n),
        .a_data_in(a_data_in), .a_par_in(a_par_in),
        .b_data_in(b_data_in), .b_par_in(b_par_in),
        .a_data_out(a_data_out), .a_par_out(a_par_out), .a_oe(a_oe),
        .b_data_out(b_data_out), .b_par_out(b_par_out), .b_oe(b_oe),
        .err_a_n(err_a_n), .err_b_n(err_b_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic pbit(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    // Compare one path's outputs with the reference view
    task automatic check_path(input string side, input logic le, input logic [15:0] din,
                              input logic [1:0] pin, input logic [15:0] sd, input logic [1:0] sp,
                              input logic [15:0] dout, input logic [1:0] pout, input logic errn);
        logic [15:0] vd;
        logic [1:0]  vp, ep;
        logic        bad;
        vd  = le ? din : sd;
        vp  = le ? pin : sp;
        bad = 1'b0;
        for (int k = 0; k < 2; k++) begin
            logic c;
            c = pbit(vd[k*8 +: 8], odd_sel);
            ep[k] = par_mode_n ? vp[k] : c;
            if (!par_mode_n && vp[k] != c) bad = 1'b1;
        end
        check({"R10 data ", side}, dout, vd);
        check(par_mode_n ? {"R6 parity ", side} : {"R7 parity ", side}, pout, ep);
        check({"R8 error ", side}, errn, !bad);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; par_mode_n = 1'b1; odd_sel = 1'b0;
        ab_le = 1'b1; ab_tick = 1'b1; ab_ce_n = 2'b00; ab_oe_n = 1'b1;
        ba_le = 1'b1; ba_tick = 1'b1; ba_ce_n = 2'b00; ba_oe_n = 1'b1;
        a_data_in = 16'hA5C3; a_par_in = 2'b11; b_data_in = 16'h5A3C; b_par_in = 2'b11;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; ab_le = 1'b0; ab_tick = 1'b0; ab_ce_n = 2'b11;
        ba_le = 1'b0; ba_tick = 1'b0; ba_ce_n = 2'b11;
        #1;
        // R1: storage cleared despite transparent controls during reset
        check("R1 b data", b_data_out, 16'h0);
        check("R1 a data", a_data_out, 16'h0);
        check("R1 parity", {a_par_out, b_par_out}, 4'h0);
        check("R1 flags", {err_a_n, err_b_n}, 2'b11);

        // R2: transparent, noninverting, same cycle
        @(negedge clk); ab_le = 1'b1; a_data_in = 16'h1E7B; a_par_in = 2'b10; #1;
        check("R2 transparent data", b_data_out, 16'h1E7B);
        check("R2 transparent parity", b_par_out, 2'b10);
        // R2: closing the latch keeps the last word loaded while open
        @(negedge clk); ab_le = 1'b0; a_data_in = 16'hFFFF; #1;
        check("R2 latched on close", b_data_out, 16'h1E7B);

        // R3: capture both lanes on a tick
        @(negedge clk); a_data_in = 16'h3C96; a_par_in = 2'b01; ab_tick = 1'b1; ab_ce_n = 2'b00;
        @(negedge clk); ab_tick = 1'b0; ab_ce_n = 2'b11; a_data_in = 16'h0000; #1;
        check("R3 capture data", b_data_out, 16'h3C96);
        check("R3 capture parity", b_par_out, 2'b01);

        // R4: tick low with enables low, then enables high with tick: hold
        @(negedge clk); ab_ce_n = 2'b00; a_data_in = 16'h7777;
        @(negedge clk); ab_tick = 1'b1; ab_ce_n = 2'b11;
        @(negedge clk); ab_tick = 1'b0; #1;
        check("R4 hold", b_data_out, 16'h3C96);

        // R5: only lane 0 enabled
        @(negedge clk); ab_tick = 1'b1; ab_ce_n = 2'b10; a_data_in = 16'hABCD; a_par_in = 2'b10;
        @(negedge clk); ab_tick = 1'b0; ab_ce_n = 2'b11; #1;
        check("R5 lane0 only", b_data_out, 16'h3CCD);
        check("R5 lane0 parity", b_par_out, 2'b00);
        // R5: only lane 1 enabled
        @(negedge clk); ab_tick = 1'b1; ab_ce_n = 2'b01; a_data_in = 16'h4411; a_par_in = 2'b11;
        @(negedge clk); ab_tick = 1'b0; ab_ce_n = 2'b11; #1;
        check("R5 lane1 only", b_data_out, 16'h44CD);
        check("R5 lane1 parity", b_par_out, 2'b10);

        // Bring both references to known stored state via transparent load
        @(negedge clk); ab_le = 1'b1; ba_le = 1'b1;
        a_data_in = 16'h0; a_par_in = 2'b00; b_data_in = 16'h0; b_par_in = 2'b00;
        @(posedge clk);
        m_ab_d = 16'h0; m_ab_p = 2'b00; m_ba_d = 16'h0; m_ba_p = 2'b00;

        // Sweep every AB control combination; BA runs random controls
        for (int rnd = 0; rnd < 6; rnd++) begin
            for (int c = 0; c < 256; c++) begin
                @(negedge clk);
                ab_le      = c[0];
                ab_tick    = c[1];
                ab_ce_n    = c[3:2];
                par_mode_n = c[4];
                odd_sel    = c[5];
                ab_oe_n    = c[6];
                ba_oe_n    = c[7];
                ba_le      = ($urandom_range(0, 3) == 0);
                ba_tick    = 1'($urandom);
                ba_ce_n    = 2'($urandom);
                a_data_in  = 16'($urandom);
                a_par_in   = 2'($urandom);
                b_data_in  = 16'($urandom);
                b_par_in   = 2'($urandom);
                #1;
                check_path("B", ab_le, a_data_in, a_par_in, m_ab_d, m_ab_p, b_data_out, b_par_out, err_a_n);
                check_path("A", ba_le, b_data_in, b_par_in, m_ba_d, m_ba_p, a_data_out, a_par_out, err_b_n);
                check("R9 enables", {a_oe, b_oe}, {!ba_oe_n, !ab_oe_n});
                @(posedge clk);
                for (int k = 0; k < 2; k++) begin
                    if (ab_le || (ab_tick && !ab_ce_n[k])) begin
                        m_ab_d[k*8 +: 8] = a_data_in[k*8 +: 8];
                        m_ab_p[k]        = a_par_in[k];
                    end
                    if (ba_le || (ba_tick && !ba_ce_n[k])) begin
                        m_ba_d[k*8 +: 8] = b_data_in[k*8 +: 8];
                        m_ba_p[k]        = b_par_in[k];
                    end
                end
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule